// File: doc/BRIEF.md
# Two-wire EEPROM slave controller

This block is a synthesizable slave that answers on a two-wire serial bus as a small EEPROM would. It holds 256 bytes, organised as rows of eight bytes. A host writes by sending a device address word, a one-byte word address and one or more data bytes. The host reads either from the internal address counter directly, or after it has loaded that counter with a write header. The bus pins arrive as plain levels. SDA is open-drain: the block reports only when it wants the line pulled low. Both pins are synchronised to the system clock. All bus events are detected as edges of the synchronised levels.

Written bytes are collected in a one-row buffer. When a stop condition ends a write, an internal write cycle starts. The cycle lasts a parameterised number of system clocks. While it runs the slave ignores the bus entirely, so a host can poll for completion by sending its address. When the cycle ends, the buffered bytes are copied into the array in a single clock. The write address steps only inside the current row. The read address steps across the whole array.

The controller is one state machine with these states and transitions:
- From any state except BUSY, a start condition moves to DEV.
- DEV moves to DEV_ACK on a matching address, otherwise to IGNORE.
- DEV_ACK moves to WADDR for a write or to RDATA for a read.
- WADDR moves to WADDR_ACK, then to WDATA.
- WDATA moves to WDATA_ACK, then back to WDATA.
- RDATA moves to RACK. RACK moves back to RDATA on a host acknowledge, or to IGNORE on a host not-acknowledge.
- A stop condition moves to BUSY when bytes are buffered, otherwise to IDLE.
- BUSY moves to IDLE when its timer expires.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins a new address phase from any state except the write cycle, even in the middle of a byte. A stop condition (SDA rising while SCL is high) ends the transaction. A transaction cut off part-way through a byte leaves the address counter unchanged.
- R2: The device address word is sent MSB first. Its bits 7..4 must be 1010 and bits 3..1 must equal the CHIP_SEL parameter. Bit 0 selects the direction: 1 is read, 0 is write. On a match the slave pulls SDA low during the ninth clock. On a mismatch it leaves SDA released until the next start or stop, and its counter is untouched.
- R3: In a write, the byte after the device address loads the address counter. The slave acknowledges the word address and every data byte by pulling SDA low in the ninth clock.
- R4: Each data byte goes to the address in the counter. After each byte, only counter bits 2..0 advance, wrapping within the 8-byte row, while bits 7..3 stay fixed. A ninth or later byte therefore overwrites the start of the same row. After the write, the counter holds the start address with its low three bits advanced by the byte count, modulo 8.
- R5: A stop after at least one data byte starts a write cycle of exactly WRITE_CYCLES system clocks. The buffered bytes reach the array only when that cycle ends. A stop after a header with no data bytes starts no cycle.
- R6: During the write cycle the slave ignores the bus and does not acknowledge its own address. Once the cycle has ended, it acknowledges its address again.
- R7: A read that starts with the device address (bit 0 = 1) returns the byte at the counter. The counter advances by one for every byte sent, wrapping from 255 to 0.
- R8: A random read is a write header that loads the counter, followed by a repeated start and a read address word. It returns the byte at the loaded address.
- R9: The slave keeps sending consecutive bytes while the host acknowledges each one. After a host not-acknowledge, it releases SDA and waits for a start or stop.
- R10: After reset, every array byte and the counter are zero and SDA is released.
- R11: A repeated start discards any data bytes not yet ended by a stop. They are never written and no write cycle follows. The counter keeps its advanced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus (wired-AND of all drivers) |
| sda_oe_o | output | 1 | High to pull SDA low; low to release it |

## Verification
Some properties are checked on every cycle:
- the slave drives SDA only in an acknowledge slot or a read data slot, and never during the write cycle;
- an acknowledge slot is entered only after a matching address word;
- a write keeps the row bits fixed while the low bits step;
- each new read byte advances the counter by one;
- the write cycle never leaves its state before exactly WRITE_CYCLES clocks.

The bench scenarios show the rest: which bytes land in the array, row wrap and overwrite, the read wrap from 255 to 0, random and sequential reads, busy polling, discarding on repeated start, and that an aborted or foreign-address transaction leaves the counter alone.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WADDR,
        S_WADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK,
        S_IGNORE,
        S_BUSY
    } slv_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/twi_cond_detect.sv
module twi_cond_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_level
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_d;
    logic                   sda_d;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    assign sda_level = sda_s;

endmodule

// File: rtl/twi_page_buffer.sv
module twi_page_buffer #(
    parameter int PAGE_BYTES = 8,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    wr_i,
    input  logic [PW-1:0]           slot_i,
    input  logic [7:0]              data_i,
    output logic [PAGE_BYTES*8-1:0] data_o,
    output logic [PAGE_BYTES-1:0]   mask_o,
    output logic                    any_o
);

    logic [7:0] slot_q [PAGE_BYTES];
    logic       used_q [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
                used_q[g] <= 1'b0;
            end else if (clear_i) begin
                used_q[g] <= 1'b0;
            end else if (wr_i && slot_i == PW'(g)) begin
                slot_q[g] <= data_i;
                used_q[g] <= 1'b1;
            end
        end
        assign data_o[g*8 +: 8] = slot_q[g];
        assign mask_o[g]        = used_q[g];
    end

    assign any_o = |mask_o;

endmodule

// File: rtl/twi_eeprom_mem.sv
module twi_eeprom_mem #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 8,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES),
    localparam int RW = AW - PW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [RW-1:0]           row_i,
    input  logic [PAGE_BYTES*8-1:0] data_i,
    input  logic [PAGE_BYTES-1:0]   mask_i,
    input  logic [AW-1:0]           rd_addr_i,
    output logic [7:0]              rd_data_o
);

    logic [7:0] cell_q [MEM_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) cell_q[i] <= '0;
        end else if (commit_i) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (mask_i[j]) cell_q[{row_i, PW'(j)}] <= data_i[j*8 +: 8];
            end
        end
    end

    assign rd_data_o = cell_q[rd_addr_i];

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_eeprom_pkg::*;
#(
    parameter logic [2:0] CHIP_SEL     = 3'b000,
    parameter int         MEM_BYTES    = 256,
    parameter int         PAGE_BYTES   = 8,
    parameter int         WRITE_CYCLES = 1000,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);

    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int TW = $clog2(WRITE_CYCLES + 1);

    slv_state_e        state_q, state_d;
    logic [3:0]        cnt_q, cnt_d;
    logic [7:0]        shreg_q, shreg_d;
    logic [7:0]        tx_q, tx_d;
    logic              rw_q, rw_d;
    logic              mack_q, mack_d;
    logic [AW-1:0]     addr_q, addr_d;
    logic [TW-1:0]     timer_q, timer_d;

    logic scl_rise, scl_fall, start_det, stop_det, sda_level;
    logic buf_clear, buf_wr, buf_any, commit;
    logic [PAGE_BYTES*8-1:0] buf_data;
    logic [PAGE_BYTES-1:0]   buf_mask;
    logic [7:0]              rd_data;

    twi_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_level (sda_level)
    );

    twi_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (buf_clear),
        .wr_i    (buf_wr),
        .slot_i  (addr_q[PW-1:0]),
        .data_i  (shreg_q),
        .data_o  (buf_data),
        .mask_o  (buf_mask),
        .any_o   (buf_any)
    );

    twi_eeprom_mem #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .row_i     (addr_q[AW-1:PW]),
        .data_i    (buf_data),
        .mask_i    (buf_mask),
        .rd_addr_i (addr_q),
        .rd_data_o (rd_data)
    );

    // Next-state and datapath decisions
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        shreg_d   = shreg_q;
        tx_d      = tx_q;
        rw_d      = rw_q;
        mack_d    = mack_q;
        addr_d    = addr_q;
        timer_d   = timer_q;
        buf_clear = 1'b0;
        buf_wr    = 1'b0;
        commit    = 1'b0;
        if (state_q == S_BUSY) begin
            if (timer_q == TW'(WRITE_CYCLES - 1)) begin
                commit    = 1'b1;
                buf_clear = 1'b1;
                timer_d   = '0;
                state_d   = S_IDLE;
            end else begin
                timer_d = timer_q + TW'(1);
            end
        end else if (stop_det) begin
            timer_d = '0;
            state_d = buf_any ? S_BUSY : S_IDLE;
        end else if (start_det) begin
            buf_clear = 1'b1;
            cnt_d     = '0;
            state_d   = S_DEV;
        end else begin
            unique case (state_q)
                S_DEV, S_WADDR, S_WDATA: begin
                    if (scl_rise && cnt_q != 4'd8) begin
                        shreg_d = {shreg_q[6:0], sda_level};
                        cnt_d   = cnt_q + 4'd1;
                    end else if (scl_fall && cnt_q == 4'd8) begin
                        cnt_d = '0;
                        if (state_q == S_DEV) begin
                            if (shreg_q[7:1] == {DEV_TYPE, CHIP_SEL}) begin
                                rw_d    = shreg_q[0];
                                state_d = S_DEV_ACK;
                            end else begin
                                state_d = S_IGNORE;
                            end
                        end else if (state_q == S_WADDR) begin
                            addr_d  = shreg_q[AW-1:0];
                            state_d = S_WADDR_ACK;
                        end else begin
                            buf_wr  = 1'b1;
                            addr_d  = {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
                            state_d = S_WDATA_ACK;
                        end
                    end
                end
                S_DEV_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (rw_q) begin
                            tx_d    = rd_data;
                            addr_d  = addr_q + AW'(1);
                            state_d = S_RDATA;
                        end else begin
                            state_d = S_WADDR;
                        end
                    end
                end
                S_WADDR_ACK, S_WDATA_ACK: begin
                    if (scl_fall) begin
                        cnt_d   = '0;
                        state_d = S_WDATA;
                    end
                end
                S_RDATA: begin
                    if (scl_rise) begin
                        cnt_d = cnt_q + 4'd1;
                    end else if (scl_fall) begin
                        if (cnt_q == 4'd8) begin
                            cnt_d   = '0;
                            state_d = S_RACK;
                        end else begin
                            tx_d = {tx_q[6:0], 1'b0};
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_level;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            tx_d    = rd_data;
                            addr_d  = addr_q + AW'(1);
                            state_d = S_RDATA;
                        end else begin
                            state_d = S_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            tx_q    <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            addr_q  <= '0;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shreg_q <= shreg_d;
            tx_q    <= tx_d;
            rw_q    <= rw_d;
            mack_q  <= mack_d;
            addr_q  <= addr_d;
            timer_q <= timer_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            S_DEV_ACK, S_WADDR_ACK, S_WDATA_ACK: sda_oe_o = 1'b1;
            S_RDATA:                             sda_oe_o = ~tx_q[7];
            default:                             sda_oe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/twi_eeprom_checker.sv
module twi_eeprom_checker
    import twi_eeprom_pkg::*;
#(
    parameter logic [2:0] CHIP_SEL     = 3'b000,
    parameter int         WRITE_CYCLES = 1000,
    parameter int         AW           = 8,
    parameter int         PW           = 3,
    parameter int         TW           = 10
) (
    input logic          clk,
    input logic          rst_n,
    input slv_state_e    state_q,
    input logic [7:0]    shreg_q,
    input logic [AW-1:0] addr_q,
    input logic [TW-1:0] timer_q,
    input logic          sda_oe_o
);

    AST_ADDR_MATCH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_DEV_ACK |-> shreg_q[7:1] == {DEV_TYPE, CHIP_SEL}); // R2

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_BUSY |-> !sda_oe_o); // R6

    AST_DRIVE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (state_q == S_DEV_ACK || state_q == S_WADDR_ACK ||
                      state_q == S_WDATA_ACK || state_q == S_RDATA)); // R9

    AST_ROW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WDATA_ACK && $past(state_q) == S_WDATA) |->
        (addr_q[AW-1:PW] == $past(addr_q[AW-1:PW]) &&
         addr_q[PW-1:0] == $past(addr_q[PW-1:0]) + PW'(1))); // R4

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RDATA && $past(state_q) != S_RDATA) |->
        addr_q == $past(addr_q) + AW'(1)); // R7

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_BUSY |-> timer_q < TW'(WRITE_CYCLES)); // R5

    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == S_BUSY && state_q != S_BUSY) |->
        $past(timer_q) == TW'(WRITE_CYCLES - 1)); // R5

endmodule

bind twi_eeprom_slave twi_eeprom_checker #(
    .CHIP_SEL     (CHIP_SEL),
    .WRITE_CYCLES (WRITE_CYCLES),
    .AW           (AW),
    .PW           (PW),
    .TW           (TW)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .shreg_q  (shreg_q),
    .addr_q   (addr_q),
    .timer_q  (timer_q),
    .sda_oe_o (sda_oe_o)
);

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;

    localparam int         WCYC  = 600;
    localparam int         H     = 8;
    localparam logic [2:0] CS    = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, CS, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, CS, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic sda_oe;
    logic line;

    assign line = msda & ~sda_oe;

    always #2 clk = ~clk;

    twi_eeprom_slave #(.CHIP_SEL(CS), .WRITE_CYCLES(WCYC)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (line),
        .sda_oe_o (sda_oe)
    );

    int         n_checks = 0;
    int         n_fail   = 0;
    logic [7:0] ref_mem [256];
    logic [7:0] ref_ctr;
    logic [7:0] wbuf [16];

    function automatic logic [7:0] page_step(input logic [7:0] base, input int k);
        logic [2:0] lo;
        lo = base[2:0] + k[2:0];
        return {base[7:3], lo};
    endfunction

    function automatic logic [7:0] expect_at(input logic [7:0] a);
        return ref_mem[a];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; wait_clk(2);
        scl = 1'b1;  wait_clk(H);
        msda = 1'b0; wait_clk(H);
        scl = 1'b0;  wait_clk(2);
    endtask

    task automatic bus_stop();
        msda = 1'b0; wait_clk(H);
        scl = 1'b1;  wait_clk(H);
        msda = 1'b1; wait_clk(H);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        msda = b;    wait_clk(H);
        scl = 1'b1;  wait_clk(H / 2);
        seen = line; wait_clk(H / 2);
        scl = 1'b0;  wait_clk(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~ack, s);
    endtask

    task automatic read_bytes(input int n, input string tag);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            check(tag, b, expect_at(ref_ctr), "read data");
            ref_ctr = ref_ctr + 8'd1;
        end
    endtask

    task automatic poll_ready(input logic expect_busy);
        logic ok;
        int   tries = 0;
        do begin
            bus_start();
            send_byte(DEV_W, ok);
            bus_stop();
            if (tries == 0) check(expect_busy ? "R6" : "R5", ok, !expect_busy, "first poll answer");
            tries++;
        end while (!ok && tries < 20);
        check("R6", ok, 1, "address acknowledged after write cycle");
    endtask

    task automatic tx_write(input logic [7:0] a, input int n);
        logic ok;
        bus_start();
        send_byte(DEV_W, ok);
        check("R2", ok, 1, "write address word ack");
        send_byte(a, ok);
        check("R3", ok, 1, "word address ack");
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ok);
            check("R3", ok, 1, "data byte ack");
            ref_mem[page_step(a, i)] = wbuf[i];
        end
        bus_stop();
        ref_ctr = page_step(a, n);
        if (n > 0) poll_ready(1'b1);
    endtask

    task automatic tx_read_cur(input int n, input string tag);
        logic ok;
        bus_start();
        send_byte(DEV_R, ok);
        check("R2", ok, 1, "read address word ack");
        read_bytes(n, tag);
        bus_stop();
    endtask

    task automatic tx_read_rand(input logic [7:0] a, input int n, input string tag);
        logic ok;
        bus_start();
        send_byte(DEV_W, ok);
        check("R8", ok, 1, "random read header ack");
        send_byte(a, ok);
        check("R8", ok, 1, "random read word address ack");
        bus_start();
        send_byte(DEV_R, ok);
        check("R8", ok, 1, "random read address word ack");
        ref_ctr = a;
        read_bytes(n, tag);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic       ok;
        logic       s;
        logic       low_seen;
        logic [7:0] b;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        ref_ctr = 8'h00;

        wait_clk(5);
        check("R10", sda_oe, 0, "SDA released in reset");
        rst_n = 1'b1;
        wait_clk(5);
        check("R10", sda_oe, 0, "SDA released after reset");
        tx_read_cur(2, "R10");

        // R2: foreign chip select is not acknowledged and changes nothing
        bus_start();
        send_byte({4'b1010, 3'b011, 1'b1}, ok);
        check("R2", ok, 0, "foreign address not acknowledged");
        bus_stop();
        tx_read_cur(1, "R2");

        // R5 / R8: single byte write then random read
        wbuf[0] = 8'h5A;
        tx_write(8'h12, 1);
        tx_read_rand(8'h12, 1, "R8");

        // R4: eleven bytes into one row, wrap and overwrite
        for (int i = 0; i < 11; i++) wbuf[i] = 8'hA0 + 8'(i);
        tx_write(8'h35, 11);
        tx_read_cur(1, "R4");
        tx_read_rand(8'h30, 8, "R4");

        // R7 / R9: sequential read across the array end
        for (int i = 0; i < 3; i++) wbuf[i] = 8'hC1 + 8'(i);
        tx_write(8'hFD, 3);
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        tx_write(8'h00, 2);
        tx_read_rand(8'hFD, 5, "R7");

        // R9: after a host not-acknowledge the slave stays off the line
        bus_start();
        send_byte(DEV_R, ok);
        read_bytes(1, "R9");
        low_seen = 1'b0;
        for (int i = 0; i < 9; i++) begin
            clock_bit(1'b1, s);
            if (!s) low_seen = 1'b1;
        end
        check("R9", low_seen, 0, "SDA released after not-acknowledge");
        bus_stop();

        // R5: header-only write starts no write cycle
        tx_write(8'h44, 0);
        poll_ready(1'b0);
        tx_read_cur(1, "R5");

        // R1: start in the middle of a word address byte
        bus_start();
        send_byte(DEV_W, ok);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        bus_start();
        send_byte(DEV_R, ok);
        check("R1", ok, 1, "restart mid-byte acknowledged");
        read_bytes(1, "R1");
        bus_stop();

        // R11: repeated start discards unfinished data
        bus_start();
        send_byte(DEV_W, ok);
        send_byte(8'h80, ok);
        send_byte(8'hAA, ok);
        send_byte(8'hBB, ok);
        bus_start();
        send_byte(DEV_R, ok);
        check("R11", ok, 1, "read after discarded write acknowledged");
        ref_ctr = 8'h82;
        read_bytes(1, "R11");
        bus_stop();
        poll_ready(1'b0);
        tx_read_rand(8'h80, 2, "R11");

        // Constrained random traffic
        for (int it = 0; it < 30; it++) begin
            int op;
            op = int'($urandom_range(3, 0));
            if (op == 0) begin
                int n;
                n = int'($urandom_range(10, 1));
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
                tx_write(8'($urandom), n);
            end else if (op == 1) begin
                tx_read_rand(8'($urandom), int'($urandom_range(6, 1)), "R8");
            end else if (op == 2) begin
                tx_read_cur(int'($urandom_range(4, 1)), "R7");
            end else begin
                tx_write(8'($urandom), 0);
                tx_read_cur(int'($urandom_range(3, 1)), "R9");
            end
        end

        b = 8'h00;
        check("R10", sda_oe | b[0], 0, "SDA released at end");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule